// File: doc/BRIEF.md
# PCM Line Code Decoder

This block turns a serial PCM symbol stream into plain level-coded (NRZ-L) data. Each symbol arrives on `sym_in` with a one-cycle `sym_valid` strobe. A symbol is one bit for the level, mark and space codes and for randomized level code. For bi-phase level code it is one half-bit. The configured line code picks how symbols become data bits. Decoded bits leave on `dout`, qualified by a one-cycle `dout_valid` strobe, one clock after the symbol that completes them. An optional inversion is applied to every incoming symbol before any decoding.

Bi-phase decoding is run by a small pairing state machine. Its states are `BP_OFF` (code not selected), `BP_FIRST` (waiting for the first half) and `BP_SECOND` (holding the first half). Its transitions are:
- ENTER: `BP_OFF` to `BP_FIRST`, or straight to `BP_SECOND` when a half arrives at once.
- HALF1: `BP_FIRST` to `BP_SECOND`.
- GOOD: `BP_SECOND` to `BP_FIRST`, on a pair with a mid-bit transition.
- BAD: `BP_SECOND` to `BP_FIRST`, on a pair without one.
- SLIP: `BP_SECOND` to `BP_SECOND`, on the error that completes a run of consecutive bad pairs. The latest half becomes the new first half, which moves the pairing by one half-bit.
- LEAVE: any state to `BP_OFF`, whenever another code is selected.

The randomized code is undone by a self-synchronizing descrambler. It keeps the last 23 received levels and XORs the current level with a per-length tap set. A run-length monitor raises `stuck` when the level has not changed for a programmable number of bits. The monitor works only for the codes that can legitimately lack transitions.

Top module: `pcm_linecode_dec`

## Requirements
- R1: While and right after reset, `dout_valid`, `dout`, `code_err` and `stuck` are 0. The level history, descrambler history, run count and pairing state are all cleared.
- R2: `cfg_code` selects the code: 0 NRZ-L, 1 NRZ-M, 2 NRZ-S, 3 bi-phase-L, 4 randomized NRZ-L. For codes 0, 1, 2 and 4, every accepted symbol gives `dout_valid` high for exactly the next cycle. Values 5 to 7 never produce `dout_valid`.
- R3: When `cfg_invert` is 1, each symbol is inverted before decoding. This holds for every code.
- R4: NRZ-L outputs the level. NRZ-M outputs 1 when the level differs from the previous symbol's level. NRZ-S outputs 0 when it differs. The level before the first symbol after reset counts as 0.
- R5: In bi-phase-L, a high-then-low pair decodes to 1 and a low-then-high pair to 0. `dout_valid` rises only after the second half. Pairing restarts at a first half after reset, and after any cycle in which another code is selected.
- R6: A bi-phase pair whose two halves are equal pulses `code_err` for one cycle and produces no `dout_valid`.
- R7: After `SLIP_ERRS` consecutive bad pairs, the second half of the last bad pair becomes the first half of the next pair. A good pair clears the error run.
- R8: In randomized mode, each output bit is the level XOR the levels received the listed number of symbols earlier. `cfg_rand_len` 0 selects length 11 (delays 9, 11). Value 1 selects length 13 (delays 9, 10, 12, 13). Value 2 selects length 15 (delays 14, 15). Value 3 selects length 17 (delays 14, 17). Value 4 selects length 23 (delays 18, 23). Values 5 to 7 act as 4.
- R9: In codes 0 to 2, `stuck` is high while the current run of equal levels, counting the latest symbol, is at least `cfg_stuck_len`. It drops on the first differing symbol. A length of 0 disables the flag. The run count saturates instead of wrapping.
- R10: `stuck` is never high while bi-phase-L, randomized NRZ-L or a reserved code is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol strobe |
| sym_in | input | 1 | Bit or half-bit symbol |
| cfg_code | input | 3 | Line code select |
| cfg_invert | input | 1 | Invert symbols before decoding |
| cfg_rand_len | input | 3 | Descrambler length select |
| cfg_stuck_len | input | RUN_W | Run length that flags a stuck channel, 0 disables |
| dout | output | 1 | Decoded NRZ-L bit |
| dout_valid | output | 1 | Decoded bit strobe |
| code_err | output | 1 | Bi-phase pair without mid-bit transition |
| stuck | output | 1 | Channel level unchanged for the programmed run |

## Verification
The bench builds the block with `RUN_W` = 6 and `SLIP_ERRS` = 2. The narrow run counter lets a 70-bit constant run push it past its ceiling of 63, which exposes a wrapping counter. The slip limit of 2 puts the half-bit realignment within a few symbols. At that limit, an isolated bad pair followed by a good pair can be shown not to slip. The descrambler uses its default tap sets and is exercised at every length select, including a reserved value.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    // line code selection values
    typedef enum logic [2:0] {
        CODE_NRZL = 3'd0,
        CODE_NRZM = 3'd1,
        CODE_NRZS = 3'd2,
        CODE_BIPH = 3'd3,
        CODE_RNRZ = 3'd4
    } code_e;

    // bi-phase pairing states
    typedef enum logic [1:0] {
        BP_OFF    = 2'd0,
        BP_FIRST  = 2'd1,
        BP_SECOND = 2'd2
    } bp_state_e;

    // descrambler history depth covers the longest register
    localparam int SCR_W   = 23;
    localparam int NUM_LEN = 5;

endpackage

// File: rtl/lcd_nrz.sv
module lcd_nrz
    import lcd_pkg::*;
#(
    parameter logic [SCR_W-1:0] TAPS_11 = 23'h000500,
    parameter logic [SCR_W-1:0] TAPS_13 = 23'h001B00,
    parameter logic [SCR_W-1:0] TAPS_15 = 23'h006000,
    parameter logic [SCR_W-1:0] TAPS_17 = 23'h012000,
    parameter logic [SCR_W-1:0] TAPS_23 = 23'h420000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic       lvl,
    input  logic [2:0] code,
    input  logic [2:0] len_sel,
    output logic       out_bit
);

    localparam logic [NUM_LEN-1:0][SCR_W-1:0] TAP_SET =
        {TAPS_23, TAPS_17, TAPS_15, TAPS_13, TAPS_11};

    logic             prev_q;
    logic [SCR_W-1:0] hist_q;
    logic [2:0]       len_idx;
    logic [SCR_W-1:0] mask;
    logic [SCR_W-1:0] tapped;

    // reserved length selects fall back to the longest register
    assign len_idx = (len_sel > 3'd4) ? 3'd4 : len_sel;
    assign mask    = TAP_SET[len_idx];

    // hist_q[i] holds the level received i+1 symbols ago
    for (genvar i = 0; i < SCR_W; i++) begin : g_tap
        assign tapped[i] = hist_q[i] & mask[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            hist_q <= '0;
        end else if (sym_valid) begin
            prev_q <= lvl;
            hist_q <= {hist_q[SCR_W-2:0], lvl};
        end
    end

    always_comb begin
        unique case (code)
            CODE_NRZM: out_bit = lvl ^ prev_q;
            CODE_NRZS: out_bit = ~(lvl ^ prev_q);
            CODE_RNRZ: out_bit = lvl ^ (^tapped);
            default:   out_bit = lvl;
        endcase
    end

endmodule

// File: rtl/lcd_biphase.sv
module lcd_biphase
    import lcd_pkg::*;
#(
    parameter int SLIP_ERRS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sym_valid,
    input  logic half_in,
    output logic pair_valid,
    output logic pair_bit,
    output logic pair_err
);

    localparam int ERR_W = (SLIP_ERRS < 2) ? 1 : $clog2(SLIP_ERRS);

    bp_state_e        state_q, state_d;
    logic             first_q, first_d;
    logic [ERR_W-1:0] errs_q, errs_d;
    logic             slip_due;
    logic             matched;

    assign slip_due = (errs_q == ERR_W'(SLIP_ERRS - 1));
    assign matched  = (half_in == first_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BP_OFF;
            first_q <= 1'b0;
            errs_q  <= '0;
        end else begin
            state_q <= state_d;
            first_q <= first_d;
            errs_q  <= errs_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        first_d = first_q;
        errs_d  = errs_q;
        unique case (state_q)
            BP_OFF: begin
                // ENTER
                if (sym_valid) begin
                    first_d = half_in;
                    state_d = BP_SECOND;
                end else begin
                    state_d = BP_FIRST;
                end
            end
            BP_FIRST: begin
                // HALF1
                if (sym_valid) begin
                    first_d = half_in;
                    state_d = BP_SECOND;
                end
            end
            BP_SECOND: begin
                if (sym_valid) begin
                    if (!matched) begin
                        // GOOD
                        errs_d  = '0;
                        state_d = BP_FIRST;
                    end else if (slip_due) begin
                        // SLIP: latest half opens the next pair
                        first_d = half_in;
                        errs_d  = '0;
                        state_d = BP_SECOND;
                    end else begin
                        // BAD
                        errs_d  = errs_q + ERR_W'(1);
                        state_d = BP_FIRST;
                    end
                end
            end
            default: state_d = BP_OFF;
        endcase
        if (!enable) begin
            // LEAVE
            state_d = BP_OFF;
            errs_d  = '0;
        end
    end

    // outputs
    always_comb begin
        pair_valid = 1'b0;
        pair_err   = 1'b0;
        pair_bit   = first_q;
        if (enable && sym_valid && (state_q == BP_SECOND)) begin
            pair_valid = !matched;
            pair_err   = matched;
        end
    end

endmodule

// File: rtl/lcd_stuck.sv
module lcd_stuck #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             lvl,
    input  logic             arm,
    input  logic [RUN_W-1:0] run_len,
    output logic             stuck
);

    logic             last_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;

    // saturating increment
    assign run_inc = (&run_q) ? run_q : run_q + RUN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            run_q  <= '0;
        end else begin
            if (sym_valid) begin
                last_q <= lvl;
            end
            if (!arm) begin
                run_q <= '0;
            end else if (sym_valid) begin
                run_q <= (lvl != last_q) ? RUN_W'(1) : run_inc;
            end
        end
    end

    assign stuck = arm && (run_len != '0) && (run_q >= run_len);

endmodule

// File: rtl/pcm_linecode_dec.sv
module pcm_linecode_dec
    import lcd_pkg::*;
#(
    parameter int               RUN_W     = 8,
    parameter int               SLIP_ERRS = 4,
    parameter logic [SCR_W-1:0] TAPS_11   = 23'h000500,
    parameter logic [SCR_W-1:0] TAPS_13   = 23'h001B00,
    parameter logic [SCR_W-1:0] TAPS_15   = 23'h006000,
    parameter logic [SCR_W-1:0] TAPS_17   = 23'h012000,
    parameter logic [SCR_W-1:0] TAPS_23   = 23'h420000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             sym_in,
    input  logic [2:0]       cfg_code,
    input  logic             cfg_invert,
    input  logic [2:0]       cfg_rand_len,
    input  logic [RUN_W-1:0] cfg_stuck_len,
    output logic             dout,
    output logic             dout_valid,
    output logic             code_err,
    output logic             stuck
);

    logic lvl;
    logic is_plain, is_rand, is_bp;
    logic nrz_bit;
    logic bp_valid, bp_bit, bp_err;
    logic nx_valid, nx_bit, nx_err;
    logic dout_q, dval_q, err_q;

    // polarity applied ahead of every decoder
    assign lvl = sym_in ^ cfg_invert;

    always_comb begin
        is_plain = 1'b0;
        is_rand  = 1'b0;
        is_bp    = 1'b0;
        unique case (cfg_code)
            CODE_NRZL, CODE_NRZM, CODE_NRZS: is_plain = 1'b1;
            CODE_BIPH:                       is_bp    = 1'b1;
            CODE_RNRZ:                       is_rand  = 1'b1;
            default: ;
        endcase
    end

    lcd_nrz #(
        .TAPS_11(TAPS_11),
        .TAPS_13(TAPS_13),
        .TAPS_15(TAPS_15),
        .TAPS_17(TAPS_17),
        .TAPS_23(TAPS_23)
    ) u_nrz (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_valid(sym_valid),
        .lvl      (lvl),
        .code     (cfg_code),
        .len_sel  (cfg_rand_len),
        .out_bit  (nrz_bit)
    );

    lcd_biphase #(
        .SLIP_ERRS(SLIP_ERRS)
    ) u_bp (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (is_bp),
        .sym_valid (sym_valid),
        .half_in   (lvl),
        .pair_valid(bp_valid),
        .pair_bit  (bp_bit),
        .pair_err  (bp_err)
    );

    lcd_stuck #(
        .RUN_W(RUN_W)
    ) u_stuck (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_valid(sym_valid),
        .lvl      (lvl),
        .arm      (is_plain),
        .run_len  (cfg_stuck_len),
        .stuck    (stuck)
    );

    always_comb begin
        nx_valid = 1'b0;
        nx_bit   = 1'b0;
        nx_err   = 1'b0;
        if (is_bp) begin
            nx_valid = bp_valid;
            nx_bit   = bp_bit;
            nx_err   = bp_err;
        end else if (sym_valid && (is_plain || is_rand)) begin
            nx_valid = 1'b1;
            nx_bit   = nrz_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            dval_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            dval_q <= nx_valid;
            err_q  <= nx_err;
            if (nx_valid) begin
                dout_q <= nx_bit;
            end
        end
    end

    assign dout       = dout_q;
    assign dout_valid = dval_q;
    assign code_err   = err_q;

endmodule

// File: rtl/pcm_linecode_dec_chk.sv
module pcm_linecode_dec_chk #(
    parameter int RUN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic [2:0]       cfg_code,
    input logic [RUN_W-1:0] cfg_stuck_len,
    input logic             dout_valid,
    input logic             code_err,
    input logic             stuck
);

    assert_valid_needs_sym_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(sym_valid));

    assert_reserved_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (cfg_code > 3'd4)) |=> !dout_valid);

    assert_err_not_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> !dout_valid);

    assert_err_from_biphase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> $past(sym_valid && (cfg_code == 3'd3)));

    assert_stuck_plain_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stuck |-> (cfg_code <= 3'd2));

    assert_stuck_len_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stuck_len == '0) |-> !stuck);

    assert_stuck_rise_on_sym_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stuck) && $stable(cfg_code) && $stable(cfg_stuck_len)) |-> $past(sym_valid));

endmodule

bind pcm_linecode_dec pcm_linecode_dec_chk #(.RUN_W(RUN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_valid    (sym_valid),
    .cfg_code     (cfg_code),
    .cfg_stuck_len(cfg_stuck_len),
    .dout_valid   (dout_valid),
    .code_err     (code_err),
    .stuck        (stuck)
);

// File: tb/sim_pcm_linecode_dec.sv
module sim_pcm_linecode_dec;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_W      = 6;
    localparam int SLIP_ERRS  = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sym_valid;
    logic             sym_in;
    logic [2:0]       cfg_code;
    logic             cfg_invert;
    logic [2:0]       cfg_rand_len;
    logic [RUN_W-1:0] cfg_stuck_len;
    logic             dout, dout_valid, code_err, stuck;

    int   n_tests  = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    logic tx_hist [64];

    // {code[2:0], invert, symbol, expected valid, expected data}
    localparam logic [6:0] VEC [13] = '{
        7'b000_0_1_1_1,  // NRZ-L level 1
        7'b000_0_0_1_0,  // NRZ-L level 0
        7'b000_1_0_1_1,  // NRZ-L inverted
        7'b001_0_1_1_0,  // NRZ-M no change
        7'b001_0_0_1_1,  // NRZ-M change
        7'b001_0_0_1_0,  // NRZ-M no change
        7'b001_1_0_1_1,  // NRZ-M inverted change
        7'b010_0_1_1_1,  // NRZ-S no change
        7'b010_0_0_1_0,  // NRZ-S change
        7'b010_0_0_1_1,  // NRZ-S no change
        7'b010_0_1_1_0,  // NRZ-S change
        7'b101_0_0_0_0,  // reserved code
        7'b000_0_1_1_1   // NRZ-L again
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_linecode_dec #(
        .RUN_W    (RUN_W),
        .SLIP_ERRS(SLIP_ERRS)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_valid    (sym_valid),
        .sym_in       (sym_in),
        .cfg_code     (cfg_code),
        .cfg_invert   (cfg_invert),
        .cfg_rand_len (cfg_rand_len),
        .cfg_stuck_len(cfg_stuck_len),
        .dout         (dout),
        .dout_valid   (dout_valid),
        .code_err     (code_err),
        .stuck        (stuck)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        sym_valid = 1'b0;
        sym_in    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one symbol; returns at the negedge where its result is visible
    task automatic step(input logic s);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_in    = s;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    function automatic logic tap_hit(input int sel, input int d);
        case (sel)
            0:       return (d == 9) || (d == 11);
            1:       return (d == 9) || (d == 10) || (d == 12) || (d == 13);
            2:       return (d == 14) || (d == 15);
            3:       return (d == 14) || (d == 17);
            default: return (d == 18) || (d == 23);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_code      = 3'd0;
        cfg_invert    = 1'b0;
        cfg_rand_len  = 3'd0;
        cfg_stuck_len = '0;
        do_reset();

        // R1 reset state
        chk("R1 dout_valid", dout_valid, 1'b0);
        chk("R1 dout", dout, 1'b0);
        chk("R1 code_err", code_err, 1'b0);
        chk("R1 stuck", stuck, 1'b0);

        // R2 R3 R4 vector walk
        for (int i = 0; i < 13; i++) begin
            cfg_code   = VEC[i][6:4];
            cfg_invert = VEC[i][3];
            step(VEC[i][2]);
            chk("R2 valid", dout_valid, VEC[i][1]);
            if (VEC[i][1]) begin
                if (VEC[i][3]) chk("R3 inverted data", dout, VEC[i][0]);
                else           chk("R4 data", dout, VEC[i][0]);
            end
        end
        @(negedge clk);
        chk("R2 idle no valid", dout_valid, 1'b0);

        // R5 bi-phase basics
        cfg_invert = 1'b0;
        cfg_code   = 3'd3;
        do_reset();
        step(1'b1);
        chk("R5 first half silent", dout_valid, 1'b0);
        step(1'b0);
        chk("R5 high-low valid", dout_valid, 1'b1);
        chk("R5 high-low is 1", dout, 1'b1);
        step(1'b0);
        step(1'b1);
        chk("R5 low-high is 0", dout, 1'b0);
        cfg_invert = 1'b1;
        step(1'b0);
        step(1'b1);
        chk("R3 bi-phase inverted", dout, 1'b1);
        cfg_invert = 1'b0;

        // R6 code error
        step(1'b1);
        step(1'b1);
        chk("R6 code_err", code_err, 1'b1);
        chk("R6 no data", dout_valid, 1'b0);
        // R7 good pair clears the error run
        step(1'b1);
        step(1'b0);
        chk("R7 good pair", dout, 1'b1);
        step(1'b0);
        step(1'b0);
        chk("R6 second isolated error", code_err, 1'b1);
        step(1'b1);
        chk("R7 no slip half silent", dout_valid, 1'b0);
        step(1'b0);
        chk("R7 no slip valid", dout_valid, 1'b1);
        chk("R7 no slip data", dout, 1'b1);

        // R7 slip after consecutive errors
        do_reset();
        step(1'b1);
        step(1'b1);
        chk("R7 first error", code_err, 1'b1);
        step(1'b0);
        step(1'b0);
        chk("R7 second error", code_err, 1'b1);
        step(1'b1);
        chk("R7 slipped valid", dout_valid, 1'b1);
        chk("R7 slipped data", dout, 1'b0);
        step(1'b1);
        chk("R7 realigned half", dout_valid, 1'b0);
        step(1'b0);
        chk("R7 realigned 1", dout, 1'b1);
        step(1'b0);
        step(1'b1);
        chk("R7 realigned 0", dout, 1'b0);

        // R5 pairing restarts after leaving the code
        step(1'b1);
        cfg_code = 3'd5;
        @(negedge clk);
        cfg_code = 3'd3;
        step(1'b0);
        chk("R5 restart first half", dout_valid, 1'b0);
        step(1'b1);
        chk("R5 restart valid", dout_valid, 1'b1);
        chk("R5 restart data", dout, 1'b0);

        // R9 stuck detection
        cfg_code      = 3'd0;
        cfg_stuck_len = RUN_W'(5);
        do_reset();
        for (int n = 0; n < 4; n++) step(1'b1);
        chk("R9 run 4 below 5", stuck, 1'b0);
        step(1'b1);
        chk("R9 run 5 stuck", stuck, 1'b1);
        step(1'b1);
        chk("R9 run 6 stuck", stuck, 1'b1);
        step(1'b0);
        chk("R9 change clears", stuck, 1'b0);
        cfg_stuck_len = '0;
        for (int n = 0; n < 8; n++) step(1'b0);
        chk("R9 length 0 disables", stuck, 1'b0);
        cfg_stuck_len = RUN_W'(63);
        for (int n = 0; n < 70; n++) step(1'b1);
        chk("R9 saturated run", stuck, 1'b1);
        step(1'b0);
        chk("R9 clears after saturation", stuck, 1'b0);

        // R10 no stuck in transition-rich codes
        cfg_stuck_len = RUN_W'(5);
        cfg_code      = 3'd3;
        for (int n = 0; n < 12; n++) step(1'b1);
        chk("R10 bi-phase never stuck", stuck, 1'b0);
        cfg_code = 3'd4;
        for (int n = 0; n < 12; n++) step(1'b0);
        chk("R10 randomized never stuck", stuck, 1'b0);

        // R8 descrambler at every length select
        for (int k = 0; k < 6; k++) begin
            cfg_code     = 3'd4;
            cfg_rand_len = (k == 5) ? 3'd7 : 3'(k);
            do_reset();
            for (int n = 0; n < 48; n++) begin
                logic d;
                logic fb;
                d  = (((n * 5 + k) % 7) < 3);
                fb = 1'b0;
                for (int j = 1; j <= 23; j++) begin
                    if ((n - j >= 0) && tap_hit((k > 4) ? 4 : k, j)) fb = fb ^ tx_hist[n - j];
                end
                tx_hist[n] = d ^ fb;
                step(d ^ fb);
                chk("R8 descrambled valid", dout_valid, 1'b1);
                chk("R8 descrambled data", dout, d);
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule